// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block gives a processor a two-register window onto a small store of configuration items. Each item is a byte array with its own length. Software writes a 16-bit key into the selector register to pick an item. It then reads the item through the data register, one access at a time, 1, 2, 4 or 8 bytes wide. Every access moves an internal byte cursor forward by its width. Bytes that fall beyond the end of the item read as zero, so firmware can over-read safely and detect the end of an item.

The store holds five kinds of item, all built from parameters when the block leaves reset: a 4-byte signature, a little-endian feature word, a directory of file items, the file items themselves, and one architecture-specific item. The key holds two mode bits besides the item index. The top bit selects the architecture-specific key space. The next bit marks write intent, and only with write intent set can data writes change the store. The current key, the byte cursor and a pulse on each accepted write are brought out, so that a neighbouring engine can follow the same selection state.

Top module: `cfgport_top`

## Requirements
- R1: While `rst_n` is low and after reset, `cur_key`, `cur_offset`, `rd_valid`, `rd_data` and `wr_pulse` are all zero, and every stored byte returns to its parameter-defined value.
- R2: A cycle with `sel_we` high loads `cur_key` from `sel_wdata` and clears `cur_offset` at the next clock edge. Any data access presented in that same cycle is discarded.
- R3: `acc_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. A read (`acc_valid` high, `acc_write` low) raises `rd_valid` for one cycle after the edge. In `rd_data`, lane k (bits 8k+7:8k) holds the item byte at cursor+k, and lanes at or above the width are zero. The cursor then advances by the width.
- R4: Any lane whose byte position is at or beyond the item length reads 0x00. An access that straddles the end returns the real bytes below the end and zeros from the end onward.
- R5: The cursor saturates at 2^OFS_W-1 (255 by default) rather than wrapping, and it never decreases except when a key is written.
- R6: A key that names no item acts as an item of length zero: every read returns all zeros, and the cursor still advances.
- R7: Key bit 15 selects the architecture-specific space and bits 13:0 hold the item index. Bit 14 plays no part in the lookup, so 0xC000 reads the same item as 0x8000, and 0x4020 reads the same item as 0x0020.
- R8: Key 0x0000 is the 4-byte signature. By default, bytes 0 to 3 are 0x49, 0x43, 0x46 and 0x47.
- R9: Key 0x0001 is a 4-byte little-endian feature word. Bit 0 is always 1 and bit 1 equals DMA_PRESENT, so the default word is 0x00000001.
- R10: Key 0x0019 is the directory, with length 4 + 8*NUM_FILES. It starts with the file count as a 32-bit big-endian value. For each file i, in order, follow 8 bytes: the 32-bit big-endian length, the 16-bit big-endian key (0x0020+i), and two zero bytes.
- R11: File i has key 0x0020+i, length FILE_LEN0 + i*FILE_LEN_STEP (5 and 11 by default), and byte j = 0x10*(i+1)+j. The architecture item has key 0x8000, length ARCH_LEN (6 by default), and byte j = 0xA0+j.
- R12: A data write while key bit 14 is clear is ignored. The store is unchanged, the cursor does not move, and `wr_pulse` stays low.
- R13: A data write while key bit 14 is set stores the `acc_wdata` lanes that fall inside the item. Lanes past the end are dropped and never reach a neighbouring item. The cursor advances by the width, and `wr_pulse` is high for the one cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Write strobe for the selector register |
| sel_wdata | input | 16 | Key value to select |
| acc_valid | input | 1 | Data register access strobe |
| acc_write | input | 1 | 1 = data write, 0 = data read |
| acc_size | input | 2 | Access width code (1, 2, 4 or 8 bytes) |
| acc_wdata | input | 64 | Write data, byte lane k = cursor+k |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 64 | Assembled read data |
| cur_key | output | 16 | Currently selected key |
| cur_offset | output | OFS_W | Current byte cursor |
| wr_pulse | output | 1 | One-cycle pulse after an accepted write |

## Verification
The bench targets the item end. A read that straddles the end must return real bytes up to the last one and zeros after it; a design that wraps or drops the whole access returns stale or shifted bytes. A write to the last file-0 byte with trailing lanes is followed by a read of the next item, because a design without per-lane bounds would corrupt its first byte. Selecting a key together with an access, reading through a key with the intent bit set, reading keys that name no item, and running the cursor into saturation each expose a specific fault: a dropped selector, an item looked up with the wrong index bits, garbage data, or a cursor that wraps back to zero.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   localparam int unsigned LANES     = 8;
   localparam logic [13:0] IDX_SIG   = 14'h0000;
   localparam logic [13:0] IDX_FEAT  = 14'h0001;
   localparam logic [13:0] IDX_DIR   = 14'h0019;
   localparam int unsigned IDX_FILE0 = 32'h20;
   localparam int unsigned FIXED_LEN = 4;

   function automatic int unsigned file_len(int unsigned i, int unsigned l0, int unsigned st);
      return l0 + i * st;
   endfunction

   function automatic int unsigned dir_len(int unsigned nf);
      return 4 + 8 * nf;
   endfunction

   // first byte of file i in the flat store (i == nf gives the first byte after all files)
   function automatic int unsigned file_base(int unsigned i, int unsigned nf,
                                             int unsigned l0, int unsigned st);
      int unsigned b;
      b = 2 * FIXED_LEN + dir_len(nf);
      for (int unsigned j = 0; j < i; j++) b += file_len(j, l0, st);
      return b;
   endfunction

   function automatic int unsigned max_item_len(int unsigned nf, int unsigned l0,
                                                int unsigned st, int unsigned al);
      int unsigned m;
      m = dir_len(nf);
      if (file_len(nf - 1, l0, st) > m) m = file_len(nf - 1, l0, st);
      if (al > m) m = al;
      return m;
   endfunction

endpackage

// File: rtl/cfgport_map.sv
module cfgport_map
   import cfgport_pkg::*;
#(
   parameter int unsigned NUM_FILES     = 2,
   parameter int unsigned FILE_LEN0     = 5,
   parameter int unsigned FILE_LEN_STEP = 6,
   parameter int unsigned ARCH_LEN      = 6,
   parameter int unsigned ADDR_W        = 6,
   parameter int unsigned LEN_W         = 8
)(
   input  logic [15:0]       key,
   output logic [ADDR_W-1:0] base,
   output logic [LEN_W-1:0]  len
);
   localparam int unsigned ARCH_BASE = file_base(NUM_FILES, NUM_FILES, FILE_LEN0, FILE_LEN_STEP);

   logic [13:0]          idx;
   logic [NUM_FILES-1:0] f_hit;
   logic                 arch_hit;

   assign idx = key[13:0];

   for (genvar g = 0; g < NUM_FILES; g++) begin : g_fmatch
      assign f_hit[g] = !key[15] && (idx == 14'(IDX_FILE0 + g));
   end

   if (ARCH_LEN > 0) begin : g_arch
      assign arch_hit = key[15] && (idx == 14'd0);
   end else begin : g_noarch
      assign arch_hit = 1'b0;
   end

   always_comb begin
      base = '0;
      len  = '0;
      if (!key[15]) begin
         if (idx == IDX_SIG) begin
            base = '0;
            len  = LEN_W'(FIXED_LEN);
         end else if (idx == IDX_FEAT) begin
            base = ADDR_W'(FIXED_LEN);
            len  = LEN_W'(FIXED_LEN);
         end else if (idx == IDX_DIR) begin
            base = ADDR_W'(2 * FIXED_LEN);
            len  = LEN_W'(dir_len(NUM_FILES));
         end
      end
      for (int unsigned i = 0; i < NUM_FILES; i++) begin
         if (f_hit[i]) begin
            base = ADDR_W'(file_base(i, NUM_FILES, FILE_LEN0, FILE_LEN_STEP));
            len  = LEN_W'(file_len(i, FILE_LEN0, FILE_LEN_STEP));
         end
      end
      if (arch_hit) begin
         base = ADDR_W'(ARCH_BASE);
         len  = LEN_W'(ARCH_LEN);
      end
   end

endmodule

// File: rtl/cfgport_cursor.sv
module cfgport_cursor #(
   parameter int unsigned OFS_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_we,
   input  logic [15:0]      sel_wdata,
   input  logic             step_en,
   input  logic [3:0]       step_bytes,
   output logic [15:0]      key,
   output logic [OFS_W-1:0] offset
);
   logic [OFS_W:0] sum;

   assign sum = {1'b0, offset} + (OFS_W+1)'(step_bytes);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key    <= '0;
         offset <= '0;
      end else if (sel_we) begin
         key    <= sel_wdata;
         offset <= '0;
      end else if (step_en) begin
         offset <= sum[OFS_W] ? '1 : sum[OFS_W-1:0];
      end
   end

endmodule

// File: rtl/cfgport_store.sv
module cfgport_store
   import cfgport_pkg::*;
#(
   parameter logic [31:0] SIGNATURE     = 32'h4943_4647,
   parameter bit          DMA_PRESENT   = 1'b0,
   parameter int unsigned NUM_FILES     = 2,
   parameter int unsigned FILE_LEN0     = 5,
   parameter int unsigned FILE_LEN_STEP = 6,
   parameter int unsigned ARCH_LEN      = 6,
   parameter int unsigned OFS_W         = 8,
   parameter int unsigned ADDR_W        = 6,
   parameter int unsigned TOTAL         = 50
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  len,
   input  logic [OFS_W-1:0]  offset,
   input  logic [1:0]        size,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [63:0]       wdata,
   output logic [63:0]       rd_data
);
   localparam int unsigned DIR_LEN   = dir_len(NUM_FILES);
   localparam int unsigned DIR_BASE  = 2 * FIXED_LEN;
   localparam int unsigned ARCH_BASE = file_base(NUM_FILES, NUM_FILES, FILE_LEN0, FILE_LEN_STEP);

   function automatic logic [7:0] init_byte(int unsigned a);
      int unsigned d, e, f, sz, fb;
      logic [7:0]  b;
      b = 8'h00;
      if (a < FIXED_LEN) begin
         b = SIGNATURE[8*(3-a) +: 8];
      end else if (a == FIXED_LEN) begin
         b = {6'd0, DMA_PRESENT, 1'b1};
      end else if (a >= DIR_BASE && a < DIR_BASE + DIR_LEN) begin
         d = a - DIR_BASE;
         if (d < 4) begin
            b = 8'(NUM_FILES >> (8 * (3 - d)));
         end else begin
            e  = (d - 4) / 8;
            f  = (d - 4) % 8;
            sz = file_len(e, FILE_LEN0, FILE_LEN_STEP);
            if (f < 4)       b = 8'(sz >> (8 * (3 - f)));
            else if (f == 4) b = 8'((IDX_FILE0 + e) >> 8);
            else if (f == 5) b = 8'(IDX_FILE0 + e);
         end
      end else if (a >= DIR_BASE + DIR_LEN && a < ARCH_BASE) begin
         for (int unsigned i = 0; i < NUM_FILES; i++) begin
            fb = file_base(i, NUM_FILES, FILE_LEN0, FILE_LEN_STEP);
            if (a >= fb && a < fb + file_len(i, FILE_LEN0, FILE_LEN_STEP))
               b = 8'(16 * (i + 1) + (a - fb));
         end
      end else if (a >= ARCH_BASE) begin
         b = 8'(32'hA0 + (a - ARCH_BASE));
      end
      return b;
   endfunction

   logic [7:0]        mem [TOTAL];
   logic [LANES-1:0]  lane_in;
   logic [ADDR_W-1:0] lane_addr [LANES];
   logic [63:0]       rd_next;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [OFS_W:0] pos;
      assign pos          = {1'b0, offset} + (OFS_W+1)'(g);
      assign lane_in[g]   = (4'(g) < (4'd1 << size)) && (pos < {1'b0, len});
      assign lane_addr[g] = lane_in[g] ? ADDR_W'(32'(base) + 32'(pos)) : '0;
      assign rd_next[8*g +: 8] = lane_in[g] ? mem[lane_addr[g]] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int unsigned a = 0; a < TOTAL; a++) mem[a] <= init_byte(a);
         rd_data <= '0;
      end else begin
         if (rd_en) rd_data <= rd_next;
         if (wr_en) begin
            for (int unsigned k = 0; k < LANES; k++)
               if (lane_in[k]) mem[lane_addr[k]] <= wdata[8*k +: 8];
         end
      end
   end

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
   import cfgport_pkg::*;
#(
   parameter logic [31:0] SIGNATURE     = 32'h4943_4647,
   parameter bit          DMA_PRESENT   = 1'b0,
   parameter int unsigned NUM_FILES     = 2,
   parameter int unsigned FILE_LEN0     = 5,
   parameter int unsigned FILE_LEN_STEP = 6,
   parameter int unsigned ARCH_LEN      = 6,
   parameter int unsigned OFS_W         = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_we,
   input  logic [15:0]      sel_wdata,
   input  logic             acc_valid,
   input  logic             acc_write,
   input  logic [1:0]       acc_size,
   input  logic [63:0]      acc_wdata,
   output logic             rd_valid,
   output logic [63:0]      rd_data,
   output logic [15:0]      cur_key,
   output logic [OFS_W-1:0] cur_offset,
   output logic             wr_pulse
);
   localparam int unsigned TOTAL   = file_base(NUM_FILES, NUM_FILES, FILE_LEN0, FILE_LEN_STEP) + ARCH_LEN;
   localparam int unsigned ADDR_W  = $clog2(TOTAL);
   localparam int unsigned MAX_LEN = max_item_len(NUM_FILES, FILE_LEN0, FILE_LEN_STEP, ARCH_LEN);

   if (NUM_FILES < 1 || NUM_FILES > 64) begin : g_bad_files
      $error("cfgport_top: NUM_FILES out of range");
   end
   if (OFS_W < 4 || OFS_W > 16 || MAX_LEN + LANES >= (1 << OFS_W)) begin : g_bad_ofs
      $error("cfgport_top: OFS_W too narrow for the largest item");
   end

   logic              rd_go, wr_go;
   logic [ADDR_W-1:0] item_base;
   logic [OFS_W-1:0]  item_len;

   assign rd_go = acc_valid && !acc_write && !sel_we;
   assign wr_go = acc_valid &&  acc_write && !sel_we && cur_key[14];

   cfgport_cursor #(.OFS_W(OFS_W)) u_cursor (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_we     (sel_we),
      .sel_wdata  (sel_wdata),
      .step_en    (rd_go || wr_go),
      .step_bytes (4'd1 << acc_size),
      .key        (cur_key),
      .offset     (cur_offset)
   );

   cfgport_map #(
      .NUM_FILES(NUM_FILES), .FILE_LEN0(FILE_LEN0), .FILE_LEN_STEP(FILE_LEN_STEP),
      .ARCH_LEN(ARCH_LEN), .ADDR_W(ADDR_W), .LEN_W(OFS_W)
   ) u_map (
      .key  (cur_key),
      .base (item_base),
      .len  (item_len)
   );

   cfgport_store #(
      .SIGNATURE(SIGNATURE), .DMA_PRESENT(DMA_PRESENT), .NUM_FILES(NUM_FILES),
      .FILE_LEN0(FILE_LEN0), .FILE_LEN_STEP(FILE_LEN_STEP), .ARCH_LEN(ARCH_LEN),
      .OFS_W(OFS_W), .ADDR_W(ADDR_W), .TOTAL(TOTAL)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .base    (item_base),
      .len     (item_len),
      .offset  (cur_offset),
      .size    (acc_size),
      .rd_en   (rd_go),
      .wr_en   (wr_go),
      .wdata   (acc_wdata),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         wr_pulse <= 1'b0;
      end else begin
         rd_valid <= rd_go;
         wr_pulse <= wr_go;
      end
   end

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
   parameter int unsigned OFS_W = 8
)(
   input logic             clk,
   input logic             rst_n,
   input logic             sel_we,
   input logic [15:0]      sel_wdata,
   input logic             acc_valid,
   input logic             acc_write,
   input logic [1:0]       acc_size,
   input logic             rd_valid,
   input logic [63:0]      rd_data,
   input logic [15:0]      cur_key,
   input logic [OFS_W-1:0] cur_offset,
   input logic             wr_pulse
);
   localparam int unsigned STEP_SAFE = (1 << OFS_W) - 9;

   // R2: selector load clears the cursor and captures the key
   a_r2_select: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> (cur_offset == '0) && (cur_key == $past(sel_wdata)));

   // R2: an access in a selector cycle produces no read
   a_r2_sel_wins: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> !rd_valid && !wr_pulse);

   // R3: read produces valid data one cycle later
   a_r3_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && !sel_we) |=> rd_valid);

   // R3: cursor steps by the access width away from saturation
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && !sel_we && (32'(cur_offset) < STEP_SAFE))
      |=> (32'(cur_offset) == 32'($past(cur_offset)) + (32'd1 << $past(acc_size))));

   // R3: one-byte reads leave upper lanes zero
   a_r3_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && !sel_we && acc_size == 2'd0) |=> (rd_data[63:8] == 56'd0));

   // R5: cursor never moves backwards without a selector write
   a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_we |=> (cur_offset >= $past(cur_offset)));

   // R12: writes without intent change nothing
   a_r12_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !sel_we && !cur_key[14]) |=> ($stable(cur_offset) && !wr_pulse));

   // R13: every write pulse follows an accepted write
   a_r13_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> $past(acc_valid && acc_write && !sel_we && cur_key[14]));

endmodule

bind cfgport_top cfgport_chk #(.OFS_W(OFS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_we     (sel_we),
   .sel_wdata  (sel_wdata),
   .acc_valid  (acc_valid),
   .acc_write  (acc_write),
   .acc_size   (acc_size),
   .rd_valid   (rd_valid),
   .rd_data    (rd_data),
   .cur_key    (cur_key),
   .cur_offset (cur_offset),
   .wr_pulse   (wr_pulse)
);

// File: tb/sim_cfgport_top.sv
`timescale 1ns/100ps
module sim_cfgport_top;

   localparam int unsigned OFS_W = 8;
   localparam logic [1:0] OP_SEL = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

   typedef struct packed {
      logic [1:0]  op;
      logic [15:0] arg;   // key for OP_SEL, size code otherwise
      logic [63:0] wd;
      logic [63:0] exp;   // read data, or expected wr_pulse in bit 0
      logic [7:0]  ofs;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 34;
   localparam vec_t VECS [NV] = '{
      '{OP_SEL, 16'h0000, 64'h0, 64'h0,                   8'd0,  8'd2},  // R2
      '{OP_RD,  16'd2,    64'h0, 64'h0000_0000_4746_4349, 8'd4,  8'd8},  // R8
      '{OP_RD,  16'd0,    64'h0, 64'h0,                   8'd5,  8'd4},  // R4
      '{OP_SEL, 16'h0001, 64'h0, 64'h0,                   8'd0,  8'd2},
      '{OP_RD,  16'd3,    64'h0, 64'h0000_0000_0000_0001, 8'd8,  8'd9},  // R9
      '{OP_SEL, 16'h0019, 64'h0, 64'h0,                   8'd0,  8'd2},
      '{OP_RD,  16'd2,    64'h0, 64'h0000_0000_0200_0000, 8'd4,  8'd10}, // R10
      '{OP_RD,  16'd3,    64'h0, 64'h0000_2000_0500_0000, 8'd12, 8'd10},
      '{OP_RD,  16'd3,    64'h0, 64'h0000_2100_0B00_0000, 8'd20, 8'd10},
      '{OP_RD,  16'd1,    64'h0, 64'h0,                   8'd22, 8'd4},
      '{OP_SEL, 16'h0021, 64'h0, 64'h0,                   8'd0,  8'd2},
      '{OP_RD,  16'd3,    64'h0, 64'h2726_2524_2322_2120, 8'd8,  8'd11}, // R11
      '{OP_RD,  16'd2,    64'h0, 64'h0000_0000_002A_2928, 8'd12, 8'd4},  // R4 straddle
      '{OP_SEL, 16'h8000, 64'h0, 64'h0,                   8'd0,  8'd7},
      '{OP_RD,  16'd1,    64'h0, 64'h0000_0000_0000_A1A0, 8'd2,  8'd11},
      '{OP_SEL, 16'hC000, 64'h0, 64'h0,                   8'd0,  8'd7},  // R7
      '{OP_RD,  16'd0,    64'h0, 64'h0000_0000_0000_00A0, 8'd1,  8'd7},
      '{OP_SEL, 16'h4020, 64'h0, 64'h0,                   8'd0,  8'd7},
      '{OP_RD,  16'd0,    64'h0, 64'h0000_0000_0000_0010, 8'd1,  8'd7},
      '{OP_SEL, 16'h0005, 64'h0, 64'h0,                   8'd0,  8'd6},  // R6
      '{OP_RD,  16'd3,    64'h0, 64'h0,                   8'd8,  8'd6},
      '{OP_SEL, 16'h8001, 64'h0, 64'h0,                   8'd0,  8'd6},
      '{OP_RD,  16'd2,    64'h0, 64'h0,                   8'd4,  8'd6},
      '{OP_SEL, 16'h0020, 64'h0, 64'h0,                   8'd0,  8'd12}, // R12
      '{OP_WR,  16'd2,    64'h5555_5555, 64'h0,           8'd0,  8'd12},
      '{OP_RD,  16'd2,    64'h0, 64'h0000_0000_1312_1110, 8'd4,  8'd12},
      '{OP_SEL, 16'h4020, 64'h0, 64'h0,                   8'd0,  8'd13}, // R13
      '{OP_WR,  16'd1,    64'hBBAA, 64'h1,                8'd2,  8'd13},
      '{OP_WR,  16'd3,    64'h8877_6655_4433_2211, 64'h1, 8'd10, 8'd13},
      '{OP_WR,  16'd0,    64'h77, 64'h1,                  8'd11, 8'd13},
      '{OP_SEL, 16'h0020, 64'h0, 64'h0,                   8'd0,  8'd13},
      '{OP_RD,  16'd3,    64'h0, 64'h0000_0033_2211_BBAA, 8'd8,  8'd13},
      '{OP_SEL, 16'h0021, 64'h0, 64'h0,                   8'd0,  8'd13},
      '{OP_RD,  16'd0,    64'h0, 64'h0000_0000_0000_0020, 8'd1,  8'd13}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sel_we = 1'b0;
   logic [15:0]      sel_wdata = '0;
   logic             acc_valid = 1'b0;
   logic             acc_write = 1'b0;
   logic [1:0]       acc_size = '0;
   logic [63:0]      acc_wdata = '0;
   logic             rd_valid;
   logic [63:0]      rd_data;
   logic [15:0]      cur_key;
   logic [OFS_W-1:0] cur_offset;
   logic             wr_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cfgport_top u0 (
      .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
      .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .cur_key(cur_key), .cur_offset(cur_offset), .wr_pulse(wr_pulse)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // present one operation at a negedge; returns at the next negedge
   task automatic run_op(input logic [1:0] op, input logic [15:0] arg, input logic [63:0] wd);
      sel_we    = (op == OP_SEL);
      sel_wdata = arg;
      acc_valid = (op != OP_SEL);
      acc_write = (op == OP_WR);
      acc_size  = arg[1:0];
      acc_wdata = wd;
      @(negedge clk);
      sel_we    = 1'b0;
      acc_valid = 1'b0;
      acc_write = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(cur_key == 16'h0 && cur_offset == '0, "R1 key/offset", {cur_key, 8'(cur_offset)}, 0);
      chk(!rd_valid && !wr_pulse && rd_data == 64'h0, "R1 outputs", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_op(VECS[i].op, VECS[i].arg, VECS[i].wd);
         case (VECS[i].op)
            OP_SEL: chk(cur_key == VECS[i].arg && cur_offset == '0 && !rd_valid,
                        $sformatf("R%0d select vec %0d", VECS[i].req, i),
                        {cur_key, 8'(cur_offset)}, {VECS[i].arg, 8'd0});
            OP_RD: begin
               chk(rd_valid && rd_data == VECS[i].exp,
                   $sformatf("R%0d read data vec %0d", VECS[i].req, i), rd_data, VECS[i].exp);
               chk(cur_offset == VECS[i].ofs,
                   $sformatf("R%0d offset vec %0d", VECS[i].req, i), 64'(cur_offset), 64'(VECS[i].ofs));
            end
            default: chk(wr_pulse == VECS[i].exp[0] && cur_offset == VECS[i].ofs && !rd_valid,
                         $sformatf("R%0d write vec %0d", VECS[i].req, i),
                         {wr_pulse, 8'(cur_offset)}, {VECS[i].exp[0], VECS[i].ofs});
         endcase
      end

      // R2: selector and read in the same cycle, selector wins
      run_op(OP_RD, 16'd0, 64'h0);
      sel_we = 1'b1; sel_wdata = 16'h0001;
      acc_valid = 1'b1; acc_write = 1'b0; acc_size = 2'd3;
      @(negedge clk);
      sel_we = 1'b0; acc_valid = 1'b0;
      chk(cur_key == 16'h0001 && cur_offset == '0 && !rd_valid, "R2 select beats access",
          {cur_key, 8'(cur_offset), 7'd0, rd_valid}, {16'h0001, 16'h0});
      run_op(OP_RD, 16'd0, 64'h0);
      chk(rd_data == 64'h1, "R2 read after combined select", rd_data, 64'h1);

      // R5: cursor saturation on the signature item
      run_op(OP_SEL, 16'h0000, 64'h0);
      for (int n = 0; n < 32; n++) run_op(OP_RD, 16'd3, 64'h0);
      chk(cur_offset == 8'hFF, "R5 saturate", 64'(cur_offset), 64'hFF);
      run_op(OP_RD, 16'd3, 64'h0);
      chk(cur_offset == 8'hFF && rd_valid && rd_data == 64'h0, "R5 stays saturated",
          {rd_data[55:0], cur_offset}, 64'hFF);

      // R1: reset mid-run restores the store and state
      rst_n = 1'b0;
      @(negedge clk);
      chk(cur_key == 16'h0 && cur_offset == '0 && !rd_valid, "R1 reset mid-run",
          {cur_key, 8'(cur_offset)}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_op(OP_SEL, 16'h0020, 64'h0);
      run_op(OP_RD, 16'd1, 64'h0);
      chk(rd_data == 64'h1110, "R1 store restored", rd_data, 64'h1110);

      finish_run();
   end

endmodule